// File: doc/BRIEF.md
# Single-Cycle Instruction Control Decoder

This block turns the opcode and function fields of a 32-bit instruction, together with the ALU zero flag, into every control line a single-cycle, word-addressed load-store datapath needs. It covers register-register arithmetic and logic, immediate arithmetic and logic, load upper immediate, word load and store, branch-if-equal, register-indirect jump, absolute jump, jump-and-link and a halt instruction. The selects are raw codes for the datapath's multiplexers: ALU operation, B-operand source, destination register, write-back source and next-PC source.

The decode path is purely combinational, so the controls settle in the same cycle the instruction is presented. The only state is a sticky halt flag. Once a halt instruction is decoded, the block raises `halt_o`. From then until a synchronous reset it keeps every register and memory write off and holds the next-PC select at sequential.

Top module: `ctl_decoder_top`

## Requirements
- R1: With opcode 0x00, function codes 0x20, 0x22, 0x24, 0x25 and 0x2A give ALU codes 000001 (add), 000010 (sub), 000011 (and), 000100 (or) and 000101 (set-less-than). Each also gives register write on, destination select 00 (rd), B from register (`alu_src_imm_o`=0), write-data select 00 (ALU), both memory strobes off and next-PC select 00.
- R2: Opcodes 0x08 (addi), 0x0D (ori) and 0x0F (lui) give ALU codes 000001, 000100 and 000110 (shift left by 16). Each also gives B from the immediate, register write on, destination select 01 (rt), write-data select 00 and next-PC select 00.
- R3: Opcode 0x23 (load) gives ALU add, immediate B, register write to rt, write-data select 01 (memory) and memory read on. Opcode 0x2B (store) gives ALU add, immediate B, memory write on and register write off. The two memory strobes are never on together.
- R4: Opcode 0x04 (beq) gives ALU sub, B from register and no writes. Next-PC select is 01 when the zero flag is 1 and 00 when it is 0.
- R5: Opcode 0x00 with function 0x08 (jr) gives next-PC select 10 with register and memory writes off.
- R6: Opcode 0x02 (j) gives next-PC select 11 with no writes. Opcode 0x03 (jal) gives next-PC select 11, register write on, destination select 10 (register 31) and write-data select 10 (PC+1).
- R7: An undefined opcode, or opcode 0x00 with an undefined function code, gives register write, memory read and memory write off, next-PC select 00 and ALU code 000001. Jumps and stores also carry ALU code 000001.
- R8: Opcode 0x3F (halt) raises `halt_o` in the same cycle, with writes and memory strobes off and next-PC select 00.
- R9: After a halt is decoded, `halt_o` stays 1 on every later cycle until reset, whatever instruction is presented. During that time register write, both memory strobes and any non-zero next-PC select are suppressed.
- R10: A synchronous reset (`rst`=1 at a clock edge) clears the halt state. The zero flag changes no output for any instruction other than beq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the halt state |
| rst | input | 1 | Synchronous active-high reset |
| opcode_i | input | 6 | Instruction bits 31:26 |
| funct_i | input | 6 | Instruction bits 5:0 |
| zero_i | input | 1 | ALU result-is-zero flag |
| alu_op_o | output | 6 | ALU operation code |
| alu_src_imm_o | output | 1 | 1: B operand from immediate, 0: from register |
| reg_we_o | output | 1 | Register file write enable |
| wr_reg_sel_o | output | 2 | Destination: 00 rd, 01 rt, 1x register 31 |
| wr_data_sel_o | output | 2 | Write-back: 00 ALU, 01 memory, 1x PC+1 |
| mem_rd_o | output | 1 | Data memory read strobe |
| mem_wr_o | output | 1 | Data memory write strobe |
| pc_sel_o | output | 2 | Next PC: 00 PC+1, 01 branch, 10 register, 11 jump target |
| halt_o | output | 1 | Execution stopped until reset |

## Verification
A table walks every defined opcode and function code, and each row compares all output fields at once. This catches a swapped ALU code, a wrong destination or write-back select, or a misrouted strobe between instructions that share an opcode. Beq is applied with the zero flag both set and clear, and add is applied with zero set, which separates a real equality test from a stuck select or a leaking flag. Undefined opcode and function values show that unknown instructions fall back to harmless defaults. A directed sequence presents halt, then later writing instructions, then reset. This shows that the halt takes effect at once, persists across edges and is cleared only by reset.

// File: rtl/ctl_pkg.sv
package ctl_pkg;

    localparam int OP_W   = 6;
    localparam int FN_W   = 6;
    localparam int ALU_W  = 6;
    localparam int SEL_W  = 2;

    typedef enum logic [OP_W-1:0] {
        OPC_RTYPE = 6'h00,
        OPC_JMP   = 6'h02,
        OPC_JAL   = 6'h03,
        OPC_BEQ   = 6'h04,
        OPC_ADDI  = 6'h08,
        OPC_ORI   = 6'h0D,
        OPC_LUI   = 6'h0F,
        OPC_LOAD  = 6'h23,
        OPC_STORE = 6'h2B,
        OPC_HALT  = 6'h3F
    } opcode_e;

    typedef enum logic [FN_W-1:0] {
        FN_JR  = 6'h08,
        FN_ADD = 6'h20,
        FN_SUB = 6'h22,
        FN_AND = 6'h24,
        FN_OR  = 6'h25,
        FN_SLT = 6'h2A
    } funct_e;

    typedef enum logic [ALU_W-1:0] {
        ALU_ADD   = 6'b000001,
        ALU_SUB   = 6'b000010,
        ALU_AND   = 6'b000011,
        ALU_OR    = 6'b000100,
        ALU_SLT   = 6'b000101,
        ALU_SHL16 = 6'b000110
    } alu_op_e;

    typedef enum logic [SEL_W-1:0] {
        NPC_SEQ    = 2'b00,
        NPC_BRANCH = 2'b01,
        NPC_REG    = 2'b10,
        NPC_TARGET = 2'b11
    } npc_sel_e;

    typedef enum logic [SEL_W-1:0] {
        DST_RD   = 2'b00,
        DST_RT   = 2'b01,
        DST_LINK = 2'b10
    } dst_sel_e;

    typedef enum logic [SEL_W-1:0] {
        WB_ALU  = 2'b00,
        WB_MEM  = 2'b01,
        WB_LINK = 2'b10
    } wb_sel_e;

    // kind of control transfer requested by the main decoder
    typedef enum logic [1:0] {
        XFER_NONE,
        XFER_COND,
        XFER_REG,
        XFER_ABS
    } xfer_e;

    typedef struct packed {
        alu_op_e  alu_op;
        logic     src_imm;
        logic     reg_we;
        dst_sel_e dst_sel;
        wb_sel_e  wb_sel;
        logic     mem_rd;
        logic     mem_wr;
        xfer_e    xfer;
        logic     halt;
    } ctl_t;

    function automatic ctl_t ctl_idle();
        ctl_t c;
        c.alu_op  = ALU_ADD;
        c.src_imm = 1'b0;
        c.reg_we  = 1'b0;
        c.dst_sel = DST_RD;
        c.wb_sel  = WB_ALU;
        c.mem_rd  = 1'b0;
        c.mem_wr  = 1'b0;
        c.xfer    = XFER_NONE;
        c.halt    = 1'b0;
        return c;
    endfunction

endpackage

// File: rtl/ctl_funct_dec.sv
module ctl_funct_dec
    import ctl_pkg::*;
(
    input  logic [FN_W-1:0] funct_i,
    output alu_op_e         alu_op_o,
    output logic            arith_o,
    output logic            jr_o
);
    always_comb begin
        alu_op_o = ALU_ADD;
        arith_o  = 1'b1;
        jr_o     = 1'b0;
        case (funct_i)
            FN_ADD:  alu_op_o = ALU_ADD;
            FN_SUB:  alu_op_o = ALU_SUB;
            FN_AND:  alu_op_o = ALU_AND;
            FN_OR:   alu_op_o = ALU_OR;
            FN_SLT:  alu_op_o = ALU_SLT;
            FN_JR: begin
                arith_o = 1'b0;
                jr_o    = 1'b1;
            end
            default: arith_o = 1'b0;
        endcase
    end

    // R1: an arithmetic function and a register jump are exclusive
    always_comb begin
        fn_excl_chk: assert (!(arith_o && jr_o));
    end
endmodule

// File: rtl/ctl_main_dec.sv
module ctl_main_dec
    import ctl_pkg::*;
(
    input  logic [OP_W-1:0] opcode_i,
    input  alu_op_e         fn_alu_op_i,
    input  logic            fn_arith_i,
    input  logic            fn_jr_i,
    output ctl_t            ctl_o
);
    always_comb begin
        ctl_o = ctl_idle();
        case (opcode_i)
            OPC_RTYPE: begin
                if (fn_arith_i) begin
                    ctl_o.alu_op = fn_alu_op_i;
                    ctl_o.reg_we = 1'b1;
                end else if (fn_jr_i) begin
                    ctl_o.xfer = XFER_REG;
                end
            end
            OPC_ADDI: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.reg_we  = 1'b1;
                ctl_o.dst_sel = DST_RT;
            end
            OPC_ORI: begin
                ctl_o.alu_op  = ALU_OR;
                ctl_o.src_imm = 1'b1;
                ctl_o.reg_we  = 1'b1;
                ctl_o.dst_sel = DST_RT;
            end
            OPC_LUI: begin
                ctl_o.alu_op  = ALU_SHL16;
                ctl_o.src_imm = 1'b1;
                ctl_o.reg_we  = 1'b1;
                ctl_o.dst_sel = DST_RT;
            end
            OPC_LOAD: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.reg_we  = 1'b1;
                ctl_o.dst_sel = DST_RT;
                ctl_o.wb_sel  = WB_MEM;
                ctl_o.mem_rd  = 1'b1;
            end
            OPC_STORE: begin
                ctl_o.src_imm = 1'b1;
                ctl_o.mem_wr  = 1'b1;
            end
            OPC_BEQ: begin
                ctl_o.alu_op = ALU_SUB;
                ctl_o.xfer   = XFER_COND;
            end
            OPC_JMP: ctl_o.xfer = XFER_ABS;
            OPC_JAL: begin
                ctl_o.xfer    = XFER_ABS;
                ctl_o.reg_we  = 1'b1;
                ctl_o.dst_sel = DST_LINK;
                ctl_o.wb_sel  = WB_LINK;
            end
            OPC_HALT: ctl_o.halt = 1'b1;
            default: ;
        endcase
    end

    // R3: a store never writes the register file
    always_comb begin
        store_no_wb_chk: assert (!(ctl_o.mem_wr && ctl_o.reg_we));
    end
endmodule

// File: rtl/ctl_next_pc.sv
module ctl_next_pc
    import ctl_pkg::*;
(
    input  xfer_e    xfer_i,
    input  logic     zero_i,
    output npc_sel_e npc_o
);
    always_comb begin
        unique case (xfer_i)
            XFER_COND: npc_o = zero_i ? NPC_BRANCH : NPC_SEQ;
            XFER_REG:  npc_o = NPC_REG;
            XFER_ABS:  npc_o = NPC_TARGET;
            default:   npc_o = NPC_SEQ;
        endcase
    end

    // R4: the branch target is chosen only on an equal compare
    always_comb begin
        br_needs_zero_chk: assert (npc_o != NPC_BRANCH || zero_i);
    end
endmodule

// File: rtl/ctl_decoder_top.sv
module ctl_decoder_top
    import ctl_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [OP_W-1:0]  opcode_i,
    input  logic [FN_W-1:0]  funct_i,
    input  logic             zero_i,
    output logic [ALU_W-1:0] alu_op_o,
    output logic             alu_src_imm_o,
    output logic             reg_we_o,
    output logic [SEL_W-1:0] wr_reg_sel_o,
    output logic [SEL_W-1:0] wr_data_sel_o,
    output logic             mem_rd_o,
    output logic             mem_wr_o,
    output logic [SEL_W-1:0] pc_sel_o,
    output logic             halt_o
);
    alu_op_e  fn_alu_op;
    logic     fn_arith;
    logic     fn_jr;
    ctl_t     ctl;
    npc_sel_e npc;
    logic     halted_q;
    logic     stop;

    ctl_funct_dec u_fn (
        .funct_i  (funct_i),
        .alu_op_o (fn_alu_op),
        .arith_o  (fn_arith),
        .jr_o     (fn_jr)
    );

    ctl_main_dec u_main (
        .opcode_i    (opcode_i),
        .fn_alu_op_i (fn_alu_op),
        .fn_arith_i  (fn_arith),
        .fn_jr_i     (fn_jr),
        .ctl_o       (ctl)
    );

    ctl_next_pc u_npc (
        .xfer_i (ctl.xfer),
        .zero_i (zero_i),
        .npc_o  (npc)
    );

    always_ff @(posedge clk) begin
        if (rst)
            halted_q <= 1'b0;
        else if (ctl.halt)
            halted_q <= 1'b1;
    end

    assign stop = halted_q | ctl.halt;

    always_comb begin
        alu_op_o      = ctl.alu_op;
        alu_src_imm_o = ctl.src_imm;
        reg_we_o      = ctl.reg_we & ~stop;
        wr_reg_sel_o  = ctl.dst_sel;
        wr_data_sel_o = ctl.wb_sel;
        mem_rd_o      = ctl.mem_rd & ~stop;
        mem_wr_o      = ctl.mem_wr & ~stop;
        pc_sel_o      = stop ? NPC_SEQ : npc;
        halt_o        = stop;
    end

    // R3
    mem_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_rd_o && mem_wr_o));

    // R9
    halt_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |=> halt_o);

    // R9
    halt_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        halt_o |-> (!reg_we_o && !mem_wr_o && !mem_rd_o && pc_sel_o == 2'b00));

    // R6
    link_chk: assert property (@(posedge clk) disable iff (rst)
        (reg_we_o && wr_reg_sel_o[1]) |-> (wr_data_sel_o[1] && pc_sel_o == 2'b11));

    // R8
    halt_op_chk: assert property (@(posedge clk) disable iff (rst)
        (opcode_i == 6'h3F) |-> halt_o);
endmodule

// File: tb/ctl_decoder_top_tb_top.sv
module ctl_decoder_top_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [5:0] opcode = 6'h00;
    logic [5:0] funct = 6'h20;
    logic       zero = 1'b0;
    logic [5:0] alu_op;
    logic       src_imm, reg_we, mem_rd, mem_wr, halt;
    logic [1:0] wrs, wds, pcs;
    int total = 0;
    int bad = 0;

    always #2 clk = ~clk;

    ctl_decoder_top dut_i (
        .clk(clk), .rst(rst), .opcode_i(opcode), .funct_i(funct), .zero_i(zero),
        .alu_op_o(alu_op), .alu_src_imm_o(src_imm), .reg_we_o(reg_we),
        .wr_reg_sel_o(wrs), .wr_data_sel_o(wds), .mem_rd_o(mem_rd),
        .mem_wr_o(mem_wr), .pc_sel_o(pcs), .halt_o(halt)
    );

    // {alu6, src, we, wrs2, wds2, mrd, mwr, pc2}
    typedef struct packed {
        logic [5:0]  op;
        logic [5:0]  fn;
        logic        z;
        logic [15:0] exp;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        '{6'h00, 6'h20, 1'b0, {6'd1, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R1 add
        '{6'h00, 6'h22, 1'b0, {6'd2, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R1 sub
        '{6'h00, 6'h24, 1'b0, {6'd3, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R1 and
        '{6'h00, 6'h25, 1'b0, {6'd4, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R1 or
        '{6'h00, 6'h2A, 1'b0, {6'd5, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R1 slt
        '{6'h00, 6'h08, 1'b0, {6'd1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b10}}, // R5 jr
        '{6'h08, 6'h00, 1'b0, {6'd1, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00}}, // R2 addi
        '{6'h0D, 6'h00, 1'b0, {6'd4, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00}}, // R2 ori
        '{6'h0F, 6'h00, 1'b0, {6'd6, 1'b1, 1'b1, 2'b01, 2'b00, 1'b0, 1'b0, 2'b00}}, // R2 lui
        '{6'h23, 6'h00, 1'b0, {6'd1, 1'b1, 1'b1, 2'b01, 2'b01, 1'b1, 1'b0, 2'b00}}, // R3 load
        '{6'h2B, 6'h00, 1'b0, {6'd1, 1'b1, 1'b0, 2'b00, 2'b00, 1'b0, 1'b1, 2'b00}}, // R3 store
        '{6'h04, 6'h00, 1'b1, {6'd2, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b01}}, // R4 taken
        '{6'h04, 6'h00, 1'b0, {6'd2, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R4 not taken
        '{6'h02, 6'h00, 1'b0, {6'd1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b11}}, // R6 j
        '{6'h03, 6'h00, 1'b0, {6'd1, 1'b0, 1'b1, 2'b10, 2'b10, 1'b0, 1'b0, 2'b11}}, // R6 jal
        '{6'h3E, 6'h00, 1'b0, {6'd1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R7 bad op
        '{6'h00, 6'h3F, 1'b0, {6'd1, 1'b0, 1'b0, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}, // R7 bad funct
        '{6'h00, 6'h20, 1'b1, {6'd1, 1'b0, 1'b1, 2'b00, 2'b00, 1'b0, 1'b0, 2'b00}}  // R10 zero on add
    };

    function automatic string tag_for(input logic [5:0] op, input logic [5:0] fn, input logic z);
        case (op)
            6'h00: begin
                if (fn == 6'h08) return "R5";
                if (fn == 6'h3F) return "R7";
                return z ? "R10" : "R1";
            end
            6'h08, 6'h0D, 6'h0F: return "R2";
            6'h23, 6'h2B: return "R3";
            6'h04: return "R4";
            6'h02, 6'h03: return "R6";
            default: return "R7";
        endcase
    endfunction

    function automatic logic [15:0] bundle();
        return {alu_op, src_imm, reg_we, wrs, wds, mem_rd, mem_wr, pcs};
    endfunction

    task automatic check(input string tag, input string what, input logic [15:0] act, input logic [15:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
        end
    endtask

    task automatic apply(input logic [5:0] op, input logic [5:0] fn, input logic z);
        @(negedge clk);
        opcode = op;
        funct = fn;
        zero = z;
        #1;
    endtask

    initial begin
        #(100000 * 4);
        bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        #1;
        // R10 reset state: no halt, add decodes normally
        check("R10", "halt after reset", {15'd0, halt}, 16'd0);
        check("R1", "add after reset", bundle(), VECS[0].exp);

        for (int i = 0; i < NV; i++) begin
            apply(VECS[i].op, VECS[i].fn, VECS[i].z);
            check(tag_for(VECS[i].op, VECS[i].fn, VECS[i].z), "table", bundle(), VECS[i].exp);
            check(tag_for(VECS[i].op, VECS[i].fn, VECS[i].z), "no halt", {15'd0, halt}, 16'd0);
        end

        // R8 halt takes effect in the same cycle
        apply(6'h3F, 6'h00, 1'b0);
        check("R8", "halt flag", {15'd0, halt}, 16'd1);
        check("R8", "halt quiet", {reg_we, mem_rd, mem_wr, pcs}, 5'b0);

        // R9 halted state persists and suppresses writes and jumps
        apply(6'h00, 6'h20, 1'b0);
        check("R9", "halt held on add", {15'd0, halt}, 16'd1);
        check("R9", "add write off", {15'd0, reg_we}, 16'd0);
        apply(6'h2B, 6'h00, 1'b0);
        check("R9", "store strobe off", {15'd0, mem_wr}, 16'd0);
        apply(6'h03, 6'h00, 1'b0);
        check("R9", "jal suppressed", {13'd0, reg_we, pcs}, 16'd0);
        apply(6'h04, 6'h00, 1'b1);
        check("R9", "branch suppressed", {14'd0, pcs}, 16'd0);
        apply(6'h23, 6'h00, 1'b0);
        check("R9", "load read off", {14'd0, mem_rd, reg_we}, 16'd0);

        // R10 synchronous reset clears halt
        @(negedge clk);
        rst = 1'b1;
        opcode = 6'h00;
        funct = 6'h20;
        @(negedge clk);
        rst = 1'b0;
        #1;
        check("R10", "halt cleared", {15'd0, halt}, 16'd0);
        check("R10", "add restored", bundle(), VECS[0].exp);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule